// File: doc/BRIEF.md
# Single-Wire EPROM Command Sequencer

This block is the byte-level controller of a single-wire slave device. Below it, a bit-slot layer turns bus time slots into whole bytes. It passes each byte written by the host to the sequencer with `rx_valid`. It asks for each byte the host reads with `rd_req`. It reports a bus reset pulse with `bus_reset`. The sequencer holds a 64-bit identifier, a 192-byte one-time-programmable data field and an 8-byte status field. Every byte of storage reads as ones until it is programmed.

Each transaction has two levels. First comes an identifier-level command, which reads the identifier, matches it, or skips it. Only a device selected at that level accepts a storage-level command. A storage-level command reads or writes the data field or the status field. It always starts with a two-byte address.

Reads stream bytes up to the end of the field and then return a 16-bit CRC. Writes buffer one byte and return a CRC. They then wait for the program pulse, which clears the bits that are zero in the buffer. After that they return the stored byte and move on to the next address. The sequencer never checks a CRC against the host. Only a bus reset ends a sequence.

Top module: `sw_eprom_seq`

## Requirements
- R1: After a bus reset, command 33h returns eight bytes on successive reads. These are the family code (default 09h), then the 48-bit serial number least significant byte first, then a CRC-8 of those seven bytes. The CRC-8 uses x^8+x^5+x^4+1, is processed LSB first, and starts from 00h. Afterwards the device is selected.
- R2: Command 55h at identifier level takes eight bytes in the same order as R1. The device is selected only if all 64 bits match. Otherwise every later read returns FFh until a bus reset.
- R3: Command CCh selects the device with no identifier exchange. Any identifier-level code other than 33h, 55h or CCh leaves the device unselected, and every read returns FFh until a bus reset.
- R4: Once the device is selected, it takes a storage command and then the address low byte and the address high byte. F0h reads the data field (0000h to 00BFh) and AAh reads the status field (0100h to 0107h). Each read request returns the byte at the current address and then increments the address.
- R5: After a read returns the last byte of its field, the next two reads return a CRC-16, low byte first. The CRC-16 uses x^16+x^15+x^2+1, is processed LSB first, and starts from 0000h. It covers the command, the two address bytes and every data byte returned. Every read after that returns FFh.
- R6: Command 0Fh writes the data field and command 55h at storage level writes the status field. After the address, one data byte goes into the buffer. The next two reads return the CRC-16 of the command, the address and that data byte, low byte first.
- R7: After the CRC, a program pulse replaces the addressed byte with its bitwise AND with the buffer. The next read returns the stored byte, and the address then increments.
- R8: After that read, the CRC-16 restarts from the value {00h, new address low byte}. The next data byte is shifted in, and two reads return the result before the next program pulse.
- R9: The program pulse leaves unchanged status byte 0107h and any address outside the field being written. The verify read returns FFh for such addresses.
- R10: A bus reset returns the device to the identifier level, unselected. A bus reset that comes in the same cycle as a program pulse awaited by a write is ignored, and programming still happens.
- R11: A read stopped by a bus reset returns no CRC. A read request just after a bus reset returns FFh.
- R12: A read whose start address is outside its field returns FFh on every request and never returns a CRC.
- R13: Each read request that does not come with a bus reset is answered by `rd_valid` in the next cycle. `rd_valid` is never high otherwise. After power-on reset all storage reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low; sets all storage to ones |
| bus_reset | input | 1 | One-cycle pulse: a bus reset pulse was detected |
| rx_valid | input | 1 | A byte written by the host is on rx_byte |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | The host starts a byte read |
| prog_pulse | input | 1 | Programming pulse applied |
| rd_valid | output | 1 | rd_byte holds the answer to the previous rd_req |
| rd_byte | output | 8 | Byte to send to the host |

## Verification
The assertions take for granted that the bit-slot layer never raises `rx_valid` and `rd_req` in the same cycle, and that `bus_reset` is a single-cycle pulse. The bench drives each input change on the falling clock edge and holds each strobe for one cycle. It never overlaps a byte write with a byte read. It raises `prog_pulse` only while a write is waiting for it, with one deliberate exception: a program pulse sent together with a bus reset.

// File: rtl/sw_eprom_seq.sv
module sw_eprom_seq #(
  parameter logic [7:0]  FAMILY     = 8'h09,
  parameter logic [47:0] SERIAL     = 48'h00A1_B2C3_D4E5,
  parameter int          DATA_BYTES = 192,
  parameter logic [15:0] STAT_BASE  = 16'h0100,
  parameter int          STAT_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rd_req,
  input  logic       prog_pulse,
  output logic       rd_valid,
  output logic [7:0] rd_byte
);
  localparam int          TOTAL    = DATA_BYTES + STAT_BYTES;
  localparam int          IW       = $clog2(TOTAL);
  localparam logic [15:0] DATA_END = 16'(DATA_BYTES);
  localparam logic [15:0] STAT_END = STAT_BASE + 16'(STAT_BYTES);

  function automatic logic [7:0] id_crc8(input logic [55:0] d);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < 56; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 8'h8C) : (r >> 1);
    return r;
  endfunction

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ b[i]) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  localparam logic [63:0] ID = {id_crc8({SERIAL, FAMILY}), SERIAL, FAMILY};

  typedef enum logic [3:0] {
    S_ROM = 4'd0, S_ROMRD = 4'd1, S_MATCH = 4'd2, S_MEM = 4'd3, S_ALO = 4'd4,
    S_AHI = 4'd5, S_RDAT = 4'd6, S_RCRC = 4'd7, S_WDAT = 4'd8, S_WCRC = 4'd9,
    S_WPROG = 4'd10, S_VFY = 4'd11, S_ONES = 4'd12
  } st_t;

  st_t         st;
  logic [7:0]  cmd, buf_q;
  logic [15:0] addr, crc;
  logic [2:0]  bcnt;
  logic        miss;
  logic [7:0]  mem [TOTAL];

  wire         is_stat  = (cmd == 8'hAA) || (cmd == 8'h55);
  wire         in_fld   = is_stat ? (addr >= STAT_BASE && addr < STAT_END) : (addr < DATA_END);
  wire         last     = is_stat ? (addr == STAT_END - 16'd1) : (addr == DATA_END - 16'd1);
  wire         wr_ok    = in_fld && !(is_stat && last);
  wire [IW-1:0] idx     = is_stat ? IW'(DATA_BYTES) + IW'(addr - STAT_BASE) : IW'(addr);
  wire [7:0]   cur      = in_fld ? mem[idx] : 8'hFF;
  wire [7:0]   id_b     = ID[{bcnt, 3'b000} +: 8];
  wire [15:0]  addr_inc = addr + 16'd1;
  wire [15:0]  crc_rx   = crc16_step(crc, rx_byte);
  wire [15:0]  crc_cur  = crc16_step(crc, cur);
  wire         prog_now = (st == S_WPROG) && prog_pulse;
  wire         is_mcmd  = rx_byte == 8'hF0 || rx_byte == 8'hAA || rx_byte == 8'h0F || rx_byte == 8'h55;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_ROM; cmd <= 8'h00; buf_q <= 8'hFF; addr <= 16'h0; crc <= 16'h0;
      bcnt <= 3'd0; miss <= 1'b0; rd_valid <= 1'b0; rd_byte <= 8'hFF;
      for (int i = 0; i < TOTAL; i++) mem[i] <= 8'hFF;
    end else begin
      rd_valid <= 1'b0;
      if (bus_reset && !prog_now) begin
        st <= S_ROM;
      end else begin
        if (prog_now) begin
          if (wr_ok) mem[idx] <= mem[idx] & buf_q;
          st <= S_VFY;
        end
        if (rx_valid) begin
          case (st)
            S_ROM: begin
              bcnt <= 3'd0; miss <= 1'b0;
              case (rx_byte)
                8'h33:   st <= S_ROMRD;
                8'h55:   st <= S_MATCH;
                8'hCC:   st <= S_MEM;
                default: st <= S_ONES;
              endcase
            end
            S_MATCH: begin
              bcnt <= bcnt + 3'd1;
              if (rx_byte != id_b) miss <= 1'b1;
              if (bcnt == 3'd7) st <= (miss || rx_byte != id_b) ? S_ONES : S_MEM;
            end
            S_MEM: begin
              cmd <= rx_byte;
              crc <= crc16_step(16'h0000, rx_byte);
              st  <= is_mcmd ? S_ALO : S_ONES;
            end
            S_ALO: begin addr[7:0] <= rx_byte; crc <= crc_rx; st <= S_AHI; end
            S_AHI: begin
              addr[15:8] <= rx_byte; crc <= crc_rx;
              st <= (cmd == 8'hF0 || cmd == 8'hAA) ? S_RDAT : S_WDAT;
            end
            S_WDAT: begin buf_q <= rx_byte; crc <= crc_rx; bcnt <= 3'd0; st <= S_WCRC; end
            default: ;
          endcase
        end
        if (rd_req) begin
          rd_valid <= 1'b1;
          rd_byte  <= 8'hFF;
          case (st)
            S_ROMRD: begin
              rd_byte <= id_b; bcnt <= bcnt + 3'd1;
              if (bcnt == 3'd7) st <= S_MEM;
            end
            S_RDAT: begin
              if (!in_fld) st <= S_ONES;
              else begin
                rd_byte <= cur; crc <= crc_cur; addr <= addr_inc;
                if (last) begin st <= S_RCRC; bcnt <= 3'd0; end
              end
            end
            S_RCRC, S_WCRC: begin
              rd_byte <= bcnt[0] ? crc[15:8] : crc[7:0];
              bcnt <= bcnt + 3'd1;
              if (bcnt[0]) st <= (st == S_RCRC) ? S_ONES : S_WPROG;
            end
            S_VFY: begin
              rd_byte <= cur; addr <= addr_inc;
              crc <= {8'h00, addr_inc[7:0]};
              st <= S_WDAT;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module sw_eprom_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_reset,
  input logic       rx_valid,
  input logic       rd_req,
  input logic       prog_pulse,
  input logic       rd_valid,
  input logic [7:0] rd_byte,
  input logic [3:0] st
);
  localparam logic [3:0] C_ROM = 4'd0, C_WPROG = 4'd10, C_VFY = 4'd11;

  p_one_xfer_per_cycle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rd_req));
  p_rsp_follows_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !bus_reset) |=> rd_valid);
  p_no_spurious_rsp_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  p_reset_to_rom_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !(st == C_WPROG && prog_pulse)) |=> st == C_ROM);
  p_prog_beats_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_WPROG && prog_pulse) |=> st == C_VFY);
  p_ff_after_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !prog_pulse) ##1 (rd_req && !bus_reset) |=> (rd_valid && rd_byte == 8'hFF));
endmodule

bind sw_eprom_seq sw_eprom_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid), .rd_req(rd_req),
  .prog_pulse(prog_pulse), .rd_valid(rd_valid), .rd_byte(rd_byte), .st(st)
);

// File: tb/sw_eprom_seq_tb_top.sv
module sw_eprom_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  FAM = 8'h09;
  localparam logic [47:0] SER = 48'h00A1_B2C3_D4E5;

  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0, rx_valid = 1'b0, rd_req = 1'b0, prog_pulse = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic rd_valid;
  logic [7:0] rd_byte;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sw_eprom_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rd_req(rd_req), .prog_pulse(prog_pulse), .rd_valid(rd_valid), .rd_byte(rd_byte)
  );

  function automatic logic [15:0] m_crc16(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = r[0] ^ b[k];
      r = r >> 1;
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  function automatic logic [7:0] m_crc8(input logic [55:0] d);
    logic [7:0] r = 8'h00;
    for (int k = 0; k < 56; k++) begin
      logic fb = r[0] ^ d[k];
      r = r >> 1;
      if (fb) r = r ^ 8'h8C;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic rdb(output logic [15:0] v);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    v = rd_valid ? {8'h00, rd_byte} : 16'hDEAD;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] e);
    logic [15:0] v;
    rdb(v);
    chk(req, v, {8'h00, e});
  endtask

  task automatic crc_chk(input string req, input logic [15:0] c);
    rd_chk(req, c[7:0]);
    rd_chk(req, c[15:8]);
  endtask

  task automatic breset();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic ppulse();
    @(negedge clk); prog_pulse = 1'b1;
    @(negedge clk); prog_pulse = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R13 rd_valid idle after reset", {15'd0, rd_valid}, 16'd0);
    rd_chk("R11 read at identifier level", 8'hFF);
  endtask

  task automatic t_read_id();
    logic [63:0] id = {m_crc8({SER, FAM}), SER, FAM};
    breset(); send(8'h33);
    for (int i = 0; i < 8; i++) rd_chk("R1 identifier byte", id[i*8 +: 8]);
    send(8'hF0); send(8'hBF); send(8'h00);
    rd_chk("R1 selected after id read", 8'hFF);
    crc_chk("R1 selected crc", m_crc16(m_crc16(m_crc16(m_crc16(16'h0, 8'hF0), 8'hBF), 8'h00), 8'hFF));
  endtask

  task automatic t_match();
    logic [63:0] id = {m_crc8({SER, FAM}), SER, FAM};
    breset(); send(8'h55);
    for (int i = 0; i < 8; i++) send(i == 3 ? id[i*8 +: 8] ^ 8'h10 : id[i*8 +: 8]);
    send(8'hF0); send(8'hBF); send(8'h00);
    rd_chk("R2 mismatch stays unselected", 8'hFF);
    rd_chk("R2 mismatch no crc", 8'hFF);
    breset(); send(8'h55);
    for (int i = 0; i < 8; i++) send(id[i*8 +: 8]);
    send(8'hF0); send(8'hBF); send(8'h00);
    rd_chk("R2 match selects", 8'hFF);
    crc_chk("R2 match crc", m_crc16(m_crc16(m_crc16(m_crc16(16'h0, 8'hF0), 8'hBF), 8'h00), 8'hFF));
    breset(); send(8'h77); send(8'hF0); send(8'hBF); send(8'h00);
    rd_chk("R3 unknown identifier code", 8'hFF);
    rd_chk("R3 unknown code no crc", 8'hFF);
  endtask

  task automatic t_read_tail();
    logic [15:0] c = 16'h0;
    breset(); send(8'hCC); send(8'hF0); send(8'hBE); send(8'h00);
    c = m_crc16(m_crc16(m_crc16(c, 8'hF0), 8'hBE), 8'h00);
    rd_chk("R4 byte 00BEh", 8'hFF); c = m_crc16(c, 8'hFF);
    rd_chk("R4 byte 00BFh", 8'hFF); c = m_crc16(c, 8'hFF);
    crc_chk("R5 read crc", c);
    rd_chk("R5 ones after crc", 8'hFF);
  endtask

  task automatic t_write_mem();
    logic [15:0] c;
    breset(); send(8'hCC); send(8'h0F); send(8'h05); send(8'h00); send(8'hA5);
    c = m_crc16(m_crc16(m_crc16(m_crc16(16'h0, 8'h0F), 8'h05), 8'h00), 8'hA5);
    crc_chk("R6 write crc", c);
    ppulse();
    rd_chk("R7 verify programmed", 8'hA5);
    send(8'h3C);
    crc_chk("R8 restart crc", m_crc16(16'h0006, 8'h3C));
    ppulse();
    rd_chk("R7 verify next address", 8'h3C);
    breset(); send(8'hCC); send(8'h0F); send(8'h05); send(8'h00); send(8'h0F);
    crc_chk("R6 second write crc", m_crc16(m_crc16(m_crc16(m_crc16(16'h0, 8'h0F), 8'h05), 8'h00), 8'h0F));
    ppulse();
    rd_chk("R7 AND programming", 8'h05);
    breset(); send(8'hCC); send(8'hF0); send(8'h04); send(8'h00);
    rd_chk("R4 read 0004h", 8'hFF);
    rd_chk("R4 read 0005h", 8'h05);
    rd_chk("R4 read 0006h", 8'h3C);
  endtask

  task automatic t_status();
    logic [15:0] c;
    breset(); send(8'hCC); send(8'h55); send(8'h03); send(8'h01); send(8'h12);
    crc_chk("R6 status write crc", m_crc16(m_crc16(m_crc16(m_crc16(16'h0, 8'h55), 8'h03), 8'h01), 8'h12));
    ppulse();
    rd_chk("R7 status verify", 8'h12);
    breset(); send(8'hCC); send(8'hAA); send(8'h03); send(8'h01);
    rd_chk("R4 status read 0103h", 8'h12);
    breset();
    rd_chk("R11 reset mid-read no crc", 8'hFF);
    breset(); send(8'hCC); send(8'h55); send(8'h07); send(8'h01); send(8'h00);
    crc_chk("R6 locked byte crc", m_crc16(m_crc16(m_crc16(m_crc16(16'h0, 8'h55), 8'h07), 8'h01), 8'h00));
    ppulse();
    rd_chk("R9 status byte 0107h locked", 8'hFF);
    breset(); send(8'hCC); send(8'hAA); send(8'h05); send(8'h01);
    c = m_crc16(m_crc16(m_crc16(16'h0, 8'hAA), 8'h05), 8'h01);
    for (int i = 0; i < 3; i++) begin
      rd_chk("R4 status tail byte", 8'hFF); c = m_crc16(c, 8'hFF);
    end
    crc_chk("R5 status crc", c);
  endtask

  task automatic t_out_of_field();
    breset(); send(8'hCC); send(8'h0F); send(8'hC0); send(8'h00); send(8'h00);
    crc_chk("R6 out-of-field crc", m_crc16(m_crc16(m_crc16(m_crc16(16'h0, 8'h0F), 8'hC0), 8'h00), 8'h00));
    ppulse();
    rd_chk("R9 out-of-field verify", 8'hFF);
    breset(); send(8'hCC); send(8'hF0); send(8'hC0); send(8'h00);
    for (int i = 0; i < 3; i++) rd_chk("R12 out-of-field read", 8'hFF);
  endtask

  task automatic t_reset_in_pulse();
    breset(); send(8'hCC); send(8'h0F); send(8'h10); send(8'h00); send(8'h5A);
    crc_chk("R6 crc before pulse", m_crc16(m_crc16(m_crc16(m_crc16(16'h0, 8'h0F), 8'h10), 8'h00), 8'h5A));
    @(negedge clk); prog_pulse = 1'b1; bus_reset = 1'b1;
    @(negedge clk); prog_pulse = 1'b0; bus_reset = 1'b0;
    rd_chk("R10 reset ignored during pulse", 8'h5A);
    breset(); send(8'hCC); send(8'hF0); send(8'h10); send(8'h00);
    rd_chk("R10 programmed despite reset", 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_read_id();
    t_match();
    t_read_tail();
    t_write_mem();
    t_status();
    t_out_of_field();
    t_reset_in_pulse();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule